// File: doc/BRIEF.md
# Stretchable External Memory Cycle Generator

This block sits between a microcontroller core and a slow external memory bus. The core issues single-clock read or write requests. The block stretches each request into a strobed bus cycle: it drives the address, a read strobe or a write strobe, and the write data. It holds each of these for a number of whole clock cycles. That number comes from a 3-bit stretch value in a control register that software can write.

The stretch value is copied into the cycle when the request is accepted. A read is one clock shorter than a write, and the two use different strobe shapes. While a cycle runs, `busy` is high and new requests are dropped. When the address window closes, `done` pulses for one clock. For a read, the captured data is on `rdData` in that same clock.

Top module: `xmem_stretch`

## Requirements
- R1: The stretch register is 3 bits (values 0 to 7). It resets to 1 and takes `cfgStretch` on any clock edge where `cfgWe` is high.
- R2: In a read cycle with stretch s, `busy` is high and `memAddr` equals the requested address for exactly s+1 consecutive clocks, starting the clock after acceptance.
- R3: In a read cycle, `memRd` is high in every clock of the address window and in no other clock.
- R4: Read data is sampled from `memRdata` in the last clock of the read strobe and presented on `rdData` in the clock after the window.
- R5: In a write cycle with stretch s, `busy` is high and `memAddr` equals the requested address for exactly s+2 consecutive clocks.
- R6: In a write cycle, `memWr` rises in the second clock of the address window. It stays high for 1 clock when s is 0 or 1, and for s clocks when s is 2 to 7.
- R7: In a write cycle, `memWdata` equals the request data for the whole address window. When s is 1 or more, the address stays valid for at least one clock after `memWr` falls.
- R8: The stretch value in force when a request is accepted governs that whole cycle. A register write during the cycle takes effect only from the next cycle.
- R9: A request is accepted on a clock edge where `reqValid` is high and `busy` is low. A request made while `busy` is high is ignored.
- R10: `done` is high for exactly one clock per cycle: the clock right after the last clock of the address window.
- R11: Outside a cycle, `memRd` and `memWr` are low and `memAddr` and `memWdata` are zero. This is also the state after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all widths count these cycles |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write enable for the stretch register |
| cfgStretch | input | 3 | New stretch value |
| reqValid | input | 1 | Single-clock bus request |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| busy | output | 1 | High while an address window is open |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdData | output | DATA_W | Captured read data |
| memAddr | output | ADDR_W | External address bus |
| memRd | output | 1 | External read strobe |
| memWr | output | 1 | External write strobe |
| memWdata | output | DATA_W | External write data bus |
| memRdata | input | DATA_W | External read data bus |

## Verification
The assertions check, in every clock, the rules that do not depend on the stretch value. Read and write strobes never overlap, and no strobe is high outside `busy`. Address and write data hold steady inside a window. The read strobe does not drop before the window ends. `done` is a single pulse that follows a window.

Only the bench's scenarios can show the rules that depend on the stretch value. These are the exact window and strobe widths for each stretch value, the reset value of the stretch register, and the placement of the write strobe. They also include the data sampled on the last read clock, the effect of a register write made during a cycle, and a request dropped while `busy` is high.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // request accepted this edge
    logic active;   // address window open
    logic isWrite;  // current cycle is a write
    logic rdStb;    // read strobe
    logic wrStb;    // write strobe
    logic capture;  // sample read data this edge
  } xmemCtl_t;
endpackage

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int STRETCH_W   = 3,
  parameter int RST_STRETCH = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [STRETCH_W-1:0] cfgStretch,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  output xmemCtl_t             ctl,
  output logic                 busy,
  output logic                 done
);
  localparam int CW = STRETCH_W + 1;

  logic [STRETCH_W-1:0] stretchReg;
  logic [STRETCH_W-1:0] curS;
  logic [CW-1:0]        cnt;
  logic                 active;
  logic                 isWr;
  logic                 doneQ;

  logic [CW-1:0] lastIdx;
  logic [CW-1:0] wrEnd;
  logic          accept;
  logic          lastClk;

  always_comb begin
    lastIdx = isWr ? ({1'b0, curS} + CW'(1)) : {1'b0, curS};
    wrEnd   = (curS < STRETCH_W'(2)) ? CW'(1) : {1'b0, curS};
    accept  = reqValid && !active;
    lastClk = active && (cnt == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stretchReg <= STRETCH_W'(RST_STRETCH);
    end else if (cfgWe) begin
      stretchReg <= cfgStretch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      isWr   <= 1'b0;
      curS   <= '0;
      cnt    <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastClk;
      if (accept) begin
        active <= 1'b1;
        isWr   <= reqWrite;
        curS   <= stretchReg;
        cnt    <= '0;
      end else if (lastClk) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_comb begin
    ctl.load    = accept;
    ctl.active  = active;
    ctl.isWrite = isWr;
    ctl.rdStb   = active && !isWr;
    ctl.wrStb   = active && isWr && (cnt != '0) && (cnt <= wrEnd);
    ctl.capture = lastClk && !isWr;
  end

  assign busy = active;
  assign done = doneQ;
endmodule

// File: rtl/xmem_dp.sv
module xmem_dp
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xmemCtl_t          ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWrite ? reqWdata : '0;
      end
      if (ctl.capture) begin
        rdataQ <= memRdata;
      end
    end
  end

  assign memAddr  = ctl.active ? addrQ : '0;
  assign memWdata = (ctl.active && ctl.isWrite) ? wdataQ : '0;
  assign memRd    = ctl.rdStb;
  assign memWr    = ctl.wrStb;
  assign rdData   = rdataQ;
endmodule

// File: rtl/xmem_stretch.sv
module xmem_stretch
  import xmem_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int STRETCH_W   = 3,
  parameter int RST_STRETCH = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [STRETCH_W-1:0] cfgStretch,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    rdData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memRd,
  output logic                 memWr,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata
);
  xmemCtl_t ctl;

  xmem_ctrl #(
    .STRETCH_W  (STRETCH_W),
    .RST_STRETCH(RST_STRETCH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgStretch(cfgStretch),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  xmem_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memRd   (memRd),
    .memWr   (memWr),
    .rdData  (rdData)
  );
endmodule

// File: rtl/xmem_stretch_chk.sv
module xmem_stretch_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memRd,
  input logic              memWr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R6

  AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> busy); // R11

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memAddr == '0 && memWdata == '0)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R10

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr)); // R2

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memWdata)); // R7

  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(memRd)) |-> memRd); // R3
endmodule

bind xmem_stretch xmem_stretch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_xmem_stretch.sv
module sim_xmem_stretch;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [2:0]    cfgStretch = '0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          busy, done, memRd, memWr;
  logic [DW-1:0] rdData, memWdata, memRdata;
  logic [AW-1:0] memAddr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  // external memory model: data is a function of the address while read strobe is high
  assign memRdata = memRd ? (memAddr[7:0] ^ memAddr[15:8] ^ 8'h5A) : 8'h00;

  xmem_stretch u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgStretch(cfgStretch),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rdData(rdData), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // {write, stretch[2:0], addr[15:0], data[7:0]}
  localparam logic [27:0] VEC [8] = '{
    {1'b0, 3'd0, 16'h1234, 8'h00},
    {1'b0, 3'd3, 16'hBEEF, 8'h00},
    {1'b0, 3'd7, 16'h00F1, 8'h00},
    {1'b1, 3'd0, 16'h4001, 8'hC3},
    {1'b1, 3'd1, 16'h4002, 8'h3C},
    {1'b1, 3'd2, 16'h8003, 8'hA5},
    {1'b1, 3'd5, 16'h0104, 8'h5A},
    {1'b1, 3'd7, 16'hFFFE, 8'h81}
  };

  int busyN, rdN, wrN, wrFirst, wrLast, doneN, doneIdx, addrBad, wdBad;
  logic [DW-1:0] rdVal;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memFn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic setStretch(input logic [2:0] s);
    @(negedge clk);
    cfgWe = 1'b1; cfgStretch = s;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // issue one request and observe 12 clocks after acceptance
  task automatic runCycle(input bit wr, input logic [15:0] a, input logic [7:0] d,
                          input bit injCfg, input logic [2:0] cfgVal, input bit injReq);
    busyN = 0; rdN = 0; wrN = 0; wrFirst = -1; wrLast = -1;
    doneN = 0; doneIdx = -1; addrBad = 0; wdBad = 0; rdVal = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = '0; reqWdata = '0;
    for (int i = 0; i < 12; i++) begin
      if (i == 2) begin
        cfgWe = 1'b0; reqValid = 1'b0; reqAddr = '0;
      end
      if (busy) begin
        busyN++;
        if (memAddr != a) addrBad++;
        if (wr && memWdata != d) wdBad++;
      end
      if (memRd) rdN++;
      if (memWr) begin
        wrN++;
        if (wrFirst < 0) wrFirst = i;
        wrLast = i;
      end
      if (done) begin
        doneN++; doneIdx = i; rdVal = rdData;
      end
      if (i == 1 && injCfg) begin
        cfgWe = 1'b1; cfgStretch = cfgVal;
      end
      if (i == 1 && injReq) begin
        reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h7777;
      end
      @(negedge clk);
    end
  endtask

  task automatic checkCycle(input bit wr, input int s, input logic [15:0] a, input string tag);
    int expL = wr ? s + 2 : s + 1;
    int expW = (s < 2) ? 1 : s;
    check(busyN == expL, wr ? {"R5 window ", tag} : {"R2 window ", tag}, busyN, expL);
    check(addrBad == 0, wr ? {"R5 addr ", tag} : {"R2 addr ", tag}, addrBad, 0);
    check(doneN == 1 && doneIdx == expL, {"R10 done ", tag}, doneIdx, expL);
    if (wr) begin
      check(rdN == 0, {"R3 no rd in write ", tag}, rdN, 0);
      check(wrN == expW, {"R6 wr width ", tag}, wrN, expW);
      check(wrFirst == 1, {"R6 wr start ", tag}, wrFirst, 1);
      check(wdBad == 0, {"R7 wdata ", tag}, wdBad, 0);
      if (s >= 1) check(wrLast < expL - 1, {"R7 addr hold ", tag}, wrLast, expL - 2);
    end else begin
      check(rdN == expL, {"R3 rd width ", tag}, rdN, expL);
      check(wrN == 0, {"R3 no wr in read ", tag}, wrN, 0);
      check(rdVal == memFn(a), {"R4 rdata ", tag}, rdVal, memFn(a));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset/idle state
    check(!busy && !done && !memRd && !memWr, "R11 reset strobes", {busy, done, memRd, memWr}, 0);
    check(memAddr == '0 && memWdata == '0, "R11 reset bus", memAddr, 0);

    // R1 reset stretch value is 1: read window 2, write window 3
    runCycle(1'b0, 16'h0A0B, 8'h00, 1'b0, 3'd0, 1'b0);
    checkCycle(1'b0, 1, 16'h0A0B, "R1 default read");
    runCycle(1'b1, 16'h0C0D, 8'h99, 1'b0, 3'd0, 1'b0);
    checkCycle(1'b1, 1, 16'h0C0D, "R1 default write");
    check(!busy && !memRd && !memWr, "R11 idle after cycle", {busy, memRd, memWr}, 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      setStretch(VEC[v][26:24]);
      runCycle(VEC[v][27], VEC[v][23:8], VEC[v][7:0], 1'b0, 3'd0, 1'b0);
      checkCycle(VEC[v][27], int'(VEC[v][26:24]), VEC[v][23:8], $sformatf("vec%0d", v));
    end

    // R8: stretch written during a cycle does not affect it
    setStretch(3'd2);
    runCycle(1'b0, 16'h2468, 8'h00, 1'b1, 3'd6, 1'b0);
    checkCycle(1'b0, 2, 16'h2468, "R8 mid-cycle write");
    runCycle(1'b0, 16'h1357, 8'h00, 1'b0, 3'd0, 1'b0);
    checkCycle(1'b0, 6, 16'h1357, "R8 next cycle uses new value");

    // R9: request while busy is ignored
    setStretch(3'd4);
    runCycle(1'b1, 16'h3C3C, 8'h77, 1'b0, 3'd0, 1'b1);
    checkCycle(1'b1, 4, 16'h3C3C, "R9 busy request");
    check(busyN == 6, "R9 no second cycle", busyN, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule